// File: doc/BRIEF.md
# Supply and Pushbutton Reset Generator

This block produces the reset for a processor. There are two causes of reset. The first is a digital flag from an external comparator that reports the core supply as below tolerance. The second is a raw, active-low pushbutton line. The pushbutton is synchronised and then debounced: a new level counts only after it has held steady for a set number of cycles.

Either cause pulls reset active. Reset then stays active for a fixed hold time counted from the moment the last cause goes away. For the pushbutton, that moment is the accepted release. For the supply, it is the return to tolerance. If a new cause arrives during the hold, the count starts again. The block also starts its hold when its own power-on reset releases.

Two outputs are provided: an active-low reset and its active-high complement. All lengths are cycle-count parameters. At the default 50 MHz clock they give about 20 ms of debounce and about 130 ms of hold. A bench can scale them down.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_low` is 1, `sys_rst_n` is 0 and `sys_rst` is 1 in the same cycle, with no clock edge needed.
- R2: After `supply_low` falls, reset stays active through SYNC_STAGES+HOLD_CYCLES-1 rising edges. It is released at the SYNC_STAGES+HOLD_CYCLES-th edge, provided no other cause is present.
- R3: A change of the synchronised pushbutton level is accepted only after the level differs from the accepted one for DEB_CYCLES consecutive cycles. A low pulse shorter than that never produces reset.
- R4: A press (`btn_n` = 0) held long enough asserts reset at the SYNC_STAGES+DEB_CYCLES+1-th rising edge after the press. Reset stays active for as long as the button is held.
- R5: After the button is released (`btn_n` = 1), reset stays active through SYNC_STAGES+DEB_CYCLES+HOLD_CYCLES-1 edges. It is released at the SYNC_STAGES+DEB_CYCLES+HOLD_CYCLES-th edge.
- R6: A new supply-low event or accepted press during the hold reloads the hold count. Release is then timed from the end of the new cause.
- R7: While `rst_n` is 0 at a rising edge, reset is asserted. After `rst_n` returns to 1 with no cause present, reset stays active through HOLD_CYCLES-1 edges and is released at the HOLD_CYCLES-th edge.
- R8: `sys_rst` is always the logical inverse of `sys_rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the block |
| supply_low | input | 1 | 1 while the core supply is below tolerance (asynchronous) |
| btn_n | input | 1 | Raw pushbutton line, 0 when pressed (asynchronous, may bounce) |
| sys_rst_n | output | 1 | Active-low processor reset |
| sys_rst | output | 1 | Active-high processor reset |

## Verification
The hardest case to reach from the ports is a hold count that is reloaded partway through. This needs a second cause to arrive after the first one has fully cleared, but before the hold has run out. The stimulus does this in two steps. It first lets a button release pass the debouncer. It then raises the supply flag a known number of cycles into the hold, and times the release from the end of that flag. The debounce threshold is approached from both sides. One low pulse is exactly one cycle shorter than the threshold. A bouncing train is made of such short pulses and then settles into a press that is accepted.

// File: rtl/rsg_pkg.sv
// Shared helpers for the reset generator.
// Assumes: counter limits fit in 32 bits.
package rsg_pkg;

    // Bits needed to hold values 0..max_val inclusive.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/rsg_sync.sv
// Multi-stage synchroniser for one asynchronous level.
// Assumes: STAGES >= 2. RST_VAL is the level that is safe to report during reset.
module rsg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rsg_debounce.sv
// Accepts a new level only after it has differed from the current accepted
// level for DEB_CYCLES consecutive cycles.
// Assumes: the input is already synchronised. DEB_CYCLES >= 2.
module rsg_debounce
    import rsg_pkg::*;
#(
    parameter int unsigned DEB_CYCLES = 1_000_000,
    parameter logic        RST_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int unsigned RUN_W = cnt_width(DEB_CYCLES - 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(DEB_CYCLES - 1);

    logic [RUN_W-1:0] run;

    // Count the length of a disagreeing run and flip the level at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= RST_VAL;
            run   <= '0;
        end else if (raw == level) begin
            run <= '0;
        end else if (run == RUN_LAST) begin
            level <= raw;
            run   <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // R3: the accepted level only moves to the input level, and only at the end of a full run
    assert_accept_full_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(raw) == level && $past(run) == RUN_LAST));

    // R3: the run counter never passes its limit
    assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RUN_LAST);
endmodule

// File: rtl/rsg_hold_timer.sv
// Holds a busy flag while any cause is present. It keeps busy for HOLD_CYCLES
// more edges once the cause clears. A new cause reloads the count.
// Assumes: the cause is synchronous to clk. HOLD_CYCLES >= 1.
module rsg_hold_timer
    import rsg_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 6_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    output logic busy
);
    localparam int unsigned HOLD_W = cnt_width(HOLD_CYCLES);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES);

    logic [HOLD_W-1:0] remain;

    // Reload on reset or on a cause, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || cause)  remain <= HOLD_LOAD;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R7: the block leaves its own reset with the hold loaded
    assert_por_loads_R7: assert property (@(posedge clk)
        !rst_n |=> (busy && remain == HOLD_LOAD));

    // R6: any cause restarts the full hold
    assert_cause_reloads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> (remain == HOLD_LOAD));

    // R2: with no cause, the hold drains by exactly one per cycle
    assert_drains_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause && busy) |=> (remain == HOLD_W'($past(remain) - 1'b1)));

    // R5: busy never drops while a cause is present
    assert_no_drop_with_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(cause));
endmodule

// File: rtl/rst_supervisor.sv
// Processor reset generator. Reset is driven by a supply-low flag (which acts
// at once) and by a debounced pushbutton. It is stretched by a hold time after
// the last cause clears.
// Assumes: supply_low and btn_n are asynchronous. rst_n is synchronous.
module rst_supervisor #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_CYCLES  = 1_000_000,
    parameter int unsigned HOLD_CYCLES = 6_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic btn_n,
    output logic sys_rst_n,
    output logic sys_rst
);
    logic supply_low_s;
    logic btn_n_s;
    logic btn_n_deb;
    logic hold_cause;
    logic hold_busy;

    rsg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_supply (
        .clk(clk), .rst_n(rst_n), .d(supply_low), .q(supply_low_s)
    );

    rsg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_btn (
        .clk(clk), .rst_n(rst_n), .d(btn_n), .q(btn_n_s)
    );

    rsg_debounce #(.DEB_CYCLES(DEB_CYCLES), .RST_VAL(1'b1)) u_debounce (
        .clk(clk), .rst_n(rst_n), .raw(btn_n_s), .level(btn_n_deb)
    );

    // A cause is a low synchronised supply or an accepted press.
    assign hold_cause = supply_low_s | ~btn_n_deb;

    rsg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .cause(hold_cause), .busy(hold_busy)
    );

    // Supply-low bypasses the synchroniser so reset acts without a clock.
    always_comb begin
        sys_rst   = supply_low | hold_busy;
        sys_rst_n = ~sys_rst;
    end

    // R1: a low supply is always seen as reset at the outputs
    assert_supply_forces_R1: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> (!sys_rst_n && sys_rst));

    // R4: an accepted press keeps reset active from the next edge on
    assert_press_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_n_deb |=> !sys_rst_n);
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
    localparam int unsigned SYNC = 2;
    localparam int unsigned DEB  = 4;
    localparam int unsigned HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0;
    logic btn_n = 1'b1;
    logic sys_rst_n;
    logic sys_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rst_supervisor #(.SYNC_STAGES(SYNC), .DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) u_rst_supervisor (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .btn_n(btn_n),
        .sys_rst_n(sys_rst_n), .sys_rst(sys_rst)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare sys_rst_n with the expected level. Also check the complement (R8).
    task automatic chk(input string req, input logic exp_n);
        checks++;
        if (sys_rst_n !== exp_n) begin
            fails++;
            $display("FAIL %s: sys_rst_n=%0b expected %0b at %0t", req, sys_rst_n, exp_n, $time);
        end
        checks++;
        if (sys_rst !== ~exp_n) begin
            fails++;
            $display("FAIL R8 (%s): sys_rst=%0b expected %0b", req, sys_rst, ~exp_n);
        end
    endtask

    task automatic t_power_on;
        step(3);
        chk("R7 during rst_n", 1'b0);
        rst_n = 1'b1;
        step(HOLD - 1);
        chk("R7 last held edge", 1'b0);
        step(1);
        chk("R7 release", 1'b1);
    endtask

    task automatic t_supply;
        supply_low = 1'b1;
        #1;
        chk("R1 immediate", 1'b0);
        step(5);
        chk("R1 while low", 1'b0);
        supply_low = 1'b0;
        step(SYNC + HOLD - 1);
        chk("R2 last held edge", 1'b0);
        step(1);
        chk("R2 release", 1'b1);
    endtask

    task automatic t_glitch;
        bit seen = 1'b0;
        btn_n = 1'b0;
        step(DEB - 1);
        btn_n = 1'b1;
        for (int i = 0; i < SYNC + DEB + 10; i++) begin
            step(1);
            if (sys_rst_n !== 1'b1) seen = 1'b1;
        end
        checks++;
        if (seen) begin
            fails++;
            $display("FAIL R3 short pulse: sys_rst_n=0 expected 1");
        end
    endtask

    task automatic t_press;
        btn_n = 1'b0;
        step(SYNC + DEB);
        chk("R4 before accept", 1'b1);
        step(1);
        chk("R4 accepted", 1'b0);
        step(15);
        chk("R4 held while pressed", 1'b0);
        btn_n = 1'b1;
        step(SYNC + DEB + HOLD - 1);
        chk("R5 last held edge", 1'b0);
        step(1);
        chk("R5 release", 1'b1);
    endtask

    task automatic t_bounce;
        for (int i = 0; i < 3; i++) begin
            btn_n = 1'b0;
            step(DEB - 1);
            btn_n = 1'b1;
            step(2);
            chk("R3 bounce ignored", 1'b1);
        end
        btn_n = 1'b0;
        step(SYNC + DEB + 1);
        chk("R3 settled press accepted", 1'b0);
        btn_n = 1'b1;
        step(SYNC + DEB + HOLD);
        chk("R5 release after bounce", 1'b1);
    endtask

    task automatic t_restart;
        btn_n = 1'b0;
        step(SYNC + DEB + 3);
        btn_n = 1'b1;
        step(SYNC + DEB + 10);
        chk("R6 inside first hold", 1'b0);
        supply_low = 1'b1;
        step(4);
        supply_low = 1'b0;
        step(SYNC + HOLD - 1);
        chk("R6 reloaded hold", 1'b0);
        step(1);
        chk("R6 release", 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_power_on();
        t_supply();
        t_glitch();
        t_press();
        t_bounce();
        t_restart();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end
endmodule